// File: doc/BRIEF.md
# Debug Port Transaction Sequencer

This block sits on the host side of a JTAG debug link. It takes one register command at a time: a read or a write, aimed at either the debug port or an access port, with a 32-bit payload. It expands that command into the scans the debug port needs. A separate scan engine performs each scan. It loads the instruction register, shifts a 35-bit data word, then spends a requested number of idle TCK cycles. The engine reports back the 3-bit acknowledge and the 32 bits it captured.

The sequencer keeps a copy of the access-port bank it last programmed, so a bank-select write is sent only when the bank changes. Every read is finished by a second scan of the read buffer, because a JTAG read returns its data one scan late. After each command a status phase reads the control/status register. That phase retries while the port answers WAIT and aborts once a retry budget is spent. It rejects unknown acknowledges, and it separates a sticky fault from lost debug power. For a sticky fault it clears the sticky bits first and then reports. Each command ends with a single-cycle response that carries a status code and the read data.

Top module: `dbg_txn_seq`

## Requirements
- R1: After reset `cmd_ready` is 1, `scan_req` is 0 and `rsp_valid` is 0, and the bank copy is empty, so the first access-port command always sends a bank-select write.
- R2: An access-port command whose bank (`cmd_addr[7:4]`) differs from the kept bank first sends a debug-port write scan (instruction 4'hA) to the select register (A=2'b10). Its data is `{cfg_ap_num, 16'h0, bank, 4'h0}`. A command to the kept bank sends no such write.
- R3: The data word of every scan is `scan_dr = {data[31:0], A[1:0], RnW}`, with RnW in bit 0. The command scan uses instruction 4'hB for an access port and 4'hA for the debug port, with A = `cmd_addr[3:2]`. Its data field is the write payload for a write and zero for a read.
- R4: A read command's access scan is followed by a debug-port read of the read buffer (A=2'b11, RnW=1). The captured data of that scan is returned on `rsp_rdata`.
- R5: An access-port command to address 8'h0C, or to any address 8'h10 to 8'h1F, carries `scan_idle = cfg_idle_tck` on its command scan. Every other scan carries `scan_idle = 0`, and so does that scan when `cfg_idle_tck` is 0.
- R6: Every command ends with a status phase. The phase is a debug-port read of the control/status register (A=2'b01, RnW=1) followed by a read-buffer read. The acknowledge of the read-buffer read decides the outcome: 3'b010 is OK, and 3'b001 (WAIT) repeats the pair.
- R7: When WAIT arrives after `cfg_retry_max` repeats have already been made, one abort scan is sent: instruction 4'h8, data 1, A=0, RnW=0. The status is then TIMEOUT (3'd1).
- R8: A status-phase acknowledge that is neither OK nor WAIT ends the command at once with status ACKERR (3'd2), and no further scan is sent.
- R9: If the status word has bit 1 (sticky overrun) or bit 5 (sticky error) set and bits [31:28] are all ones, a control/status write (A=2'b01, RnW=0) with data `cfg_ctrl_base | 32'h22` is sent, and the status is STICKY (3'd3).
- R10: If a sticky bit is set and bits [31:28] are not all ones, the status is POWER (3'd4) and no clearing write is sent. A clean status word gives OK (3'd0).
- R11: `cmd_ready` is high only while the block is idle, and no scan or response is active then. `rsp_valid` is a one-cycle pulse.
- R12: `scan_req` stays high with `scan_ir`, `scan_dr` and `scan_idle` stable until the cycle in which `scan_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted when both high |
| cmd_is_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 8 | Register address; [7:4] bank, [3:2] scan address |
| cmd_wdata | input | 32 | Write payload |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 3 | 0 OK, 1 TIMEOUT, 2 ACKERR, 3 STICKY, 4 POWER |
| rsp_rdata | output | 32 | Read result (zero for writes) |
| cfg_ap_num | input | 8 | Access port number placed in select bits [31:24] |
| cfg_idle_tck | input | 8 | Idle TCK count after data-register access-port scans |
| cfg_retry_max | input | 8 | WAIT repeats allowed before abort |
| cfg_ctrl_base | input | 32 | Control/status value OR-ed into the sticky clear write |
| scan_req | output | 1 | Scan requested |
| scan_ir | output | 4 | Instruction for the scan |
| scan_dr | output | 35 | Data word shifted out |
| scan_idle | output | 8 | Idle TCK cycles after the shift |
| scan_done | input | 1 | Scan complete (one-cycle) |
| scan_ack | input | 3 | Acknowledge captured by the scan |
| scan_rdata | input | 32 | Data captured by the scan |

## Verification
The bench builds the block with its default widths. During the run it changes `cfg_retry_max` between 3 and 0, and `cfg_idle_tck` between 5 and 0. With a limit of 3, two WAITs end in success and four end in an abort. With a limit of 0, a single WAIT aborts at once. An idle count of zero shows that data-register scans then carry no idle cycles. The bench's scan-engine model holds a small target register file with posted reads and write-one-to-clear sticky bits. Because of that model, bank changes, power loss and sticky clearing can all be seen in the data that later commands return.

// File: rtl/dts_pkg.sv
// Shared constants and types for the debug port transaction sequencer.
// Assumes the 4-bit JTAG instruction codes and 3-bit acknowledge codes of
// the debug port; everything else is parameterised in the modules.
package dts_pkg;

    localparam logic [3:0] IR_ABORT = 4'h8;
    localparam logic [3:0] IR_DPACC = 4'hA;
    localparam logic [3:0] IR_APACC = 4'hB;

    localparam logic [2:0] ACK_OK   = 3'b010;
    localparam logic [2:0] ACK_WAIT = 3'b001;

    localparam logic [1:0] DP_A_CTRL  = 2'b01;
    localparam logic [1:0] DP_A_SEL   = 2'b10;
    localparam logic [1:0] DP_A_RDBUF = 2'b11;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_TIMEOUT = 3'd1,
        ST_ACKERR  = 3'd2,
        ST_STICKY  = 3'd3,
        ST_POWER   = 3'd4
    } status_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SEL,
        OP_ACC,
        OP_RDB,
        OP_CSR,
        OP_ABT,
        OP_CLR
    } op_e;

endpackage

// File: rtl/dts_bank_track.sv
// Keeps the access-port bank last written to the select register.
// Assumes upd pulses exactly when a bank-select scan completes; the copy
// is empty after reset so the first access-port command programs the bank.
module dts_bank_track #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_ap,
    input  logic [BANK_W-1:0] bank,
    input  logic              upd,
    output logic              need_sel
);

    logic              valid_q;
    logic [BANK_W-1:0] bank_q;

    // Record the bank once its select write has been scanned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            bank_q  <= '0;
        end else if (upd) begin
            valid_q <= 1'b1;
            bank_q  <= bank;
        end
    end

    // A select write is needed for an access-port command to a new bank.
    always_comb begin
        need_sel = is_ap && (!valid_q || (bank_q != bank));
    end

endmodule

// File: rtl/dts_idle_pick.sv
// Chooses the idle TCK count for a command scan.
// Assumes access-port data registers sit at DRW_OFS and in bank BD_BANK;
// a zero configured count simply yields zero.
module dts_idle_pick #(
    parameter int          ADDR_W  = 8,
    parameter int          IDLE_W  = 8,
    parameter logic [7:0]  DRW_OFS = 8'h0C,
    parameter int          BD_BANK = 1
) (
    input  logic              is_ap,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDLE_W-1:0] cfg_idle,
    output logic [IDLE_W-1:0] idle
);

    localparam int BANK_LSB = 4;
    localparam int BANK_W   = ADDR_W - BANK_LSB;
    localparam logic [BANK_W-1:0] BD_CODE = BANK_W'(BD_BANK);

    logic is_data_reg;

    // Flag the data register and the banked data window.
    always_comb begin
        is_data_reg = (addr == ADDR_W'(DRW_OFS)) ||
                      (addr[ADDR_W-1:BANK_LSB] == BD_CODE);
        idle = (is_ap && is_data_reg) ? cfg_idle : '0;
    end

endmodule

// File: rtl/dts_scan_fmt.sv
// Builds the instruction, 35-bit data word and idle count of each scan.
// Assumes op is OP_NONE whenever no scan is wanted; the data word is
// {data, A[1:0], RnW} with RnW in bit 0.
module dts_scan_fmt
    import dts_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int AP_W     = 8,
    parameter int BANK_W   = 4,
    parameter int IDLE_W   = 8,
    parameter int IR_W     = 4,
    parameter int ORUN_BIT = 1,
    parameter int SERR_BIT = 5
) (
    input  op_e               op,
    input  logic              is_ap,
    input  logic              rnw,
    input  logic [1:0]        reg_a,
    input  logic [BANK_W-1:0] bank,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AP_W-1:0]   ap_num,
    input  logic [DATA_W-1:0] ctrl_base,
    input  logic [IDLE_W-1:0] acc_idle,
    output logic              req,
    output logic [IR_W-1:0]   ir,
    output logic [DATA_W+2:0] dr,
    output logic [IDLE_W-1:0] idle
);

    localparam int BANK_LSB = 4;
    localparam logic [DATA_W-1:0] STICKY_MASK =
        (DATA_W'(1) << ORUN_BIT) | (DATA_W'(1) << SERR_BIT);

    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] sel_word;
    logic [1:0]        a;
    logic              r;

    // Compose the select register value from port number and bank.
    always_comb begin
        sel_word = '0;
        sel_word[DATA_W-1 -: AP_W] = ap_num;
        sel_word[BANK_LSB +: BANK_W] = bank;
    end

    // Map the current step onto the scan fields.
    always_comb begin
        ir   = IR_W'(IR_DPACC);
        data = '0;
        a    = 2'b00;
        r    = 1'b0;
        idle = '0;
        case (op)
            OP_SEL: begin
                a    = DP_A_SEL;
                data = sel_word;
            end
            OP_ACC: begin
                ir   = is_ap ? IR_W'(IR_APACC) : IR_W'(IR_DPACC);
                a    = reg_a;
                r    = rnw;
                data = rnw ? '0 : wdata;
                idle = acc_idle;
            end
            OP_RDB: begin
                a = DP_A_RDBUF;
                r = 1'b1;
            end
            OP_CSR: begin
                a = DP_A_CTRL;
                r = 1'b1;
            end
            OP_ABT: begin
                ir   = IR_W'(IR_ABORT);
                data = DATA_W'(1);
            end
            OP_CLR: begin
                a    = DP_A_CTRL;
                data = ctrl_base | STICKY_MASK;
            end
            default: ;
        endcase
        req = (op != OP_NONE);
        dr  = {data, a, r};
    end

endmodule

// File: rtl/dts_ctrl.sv
// Step sequencer: accepts one command, walks bank select, access, read
// buffer collection and the status phase, then emits one response.
// Assumes the scan engine pulses scan_done once per requested scan.
module dts_ctrl
    import dts_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int RETRY_W  = 8,
    parameter int ORUN_BIT = 1,
    parameter int SERR_BIT = 5,
    parameter int PWR_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_is_ap,
    input  logic               cmd_rnw,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [DATA_W-1:0]  cmd_wdata,
    input  logic               need_sel,
    input  logic [RETRY_W-1:0] retry_max,
    output logic               q_is_ap,
    output logic               q_rnw,
    output logic [ADDR_W-1:0]  q_addr,
    output logic [DATA_W-1:0]  q_wdata,
    output op_e                op,
    output logic               sel_done,
    input  logic               scan_done,
    input  logic [2:0]         scan_ack,
    input  logic [DATA_W-1:0]  scan_rdata,
    output logic               rsp_valid,
    output logic [2:0]         rsp_status,
    output logic [DATA_W-1:0]  rsp_rdata
);

    typedef enum logic [3:0] {
        S_IDLE, S_PLAN, S_SEL, S_ACC, S_RDB,
        S_CSR, S_CSB, S_ABT, S_CLR, S_RSP
    } st_e;

    st_e                st_q;
    logic [RETRY_W-1:0] retry_q;
    status_e            status_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               sticky;
    logic               powered;

    // Decode the fault and power fields of a captured status word.
    always_comb begin
        sticky  = scan_rdata[ORUN_BIT] | scan_rdata[SERR_BIT];
        powered = &scan_rdata[DATA_W-1 -: PWR_W];
    end

    // Advance the step machine and hold command, result and retry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            retry_q  <= '0;
            status_q <= ST_OK;
            rdata_q  <= '0;
            q_is_ap  <= 1'b0;
            q_rnw    <= 1'b0;
            q_addr   <= '0;
            q_wdata  <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (cmd_valid) begin
                    q_is_ap  <= cmd_is_ap;
                    q_rnw    <= cmd_rnw;
                    q_addr   <= cmd_addr;
                    q_wdata  <= cmd_wdata;
                    retry_q  <= '0;
                    rdata_q  <= '0;
                    status_q <= ST_OK;
                    st_q     <= S_PLAN;
                end
                S_PLAN: st_q <= need_sel ? S_SEL : S_ACC;
                S_SEL:  if (scan_done) st_q <= S_ACC;
                S_ACC:  if (scan_done) st_q <= q_rnw ? S_RDB : S_CSR;
                S_RDB:  if (scan_done) begin
                    rdata_q <= scan_rdata;
                    st_q    <= S_CSR;
                end
                S_CSR:  if (scan_done) st_q <= S_CSB;
                S_CSB:  if (scan_done) begin
                    if (scan_ack == ACK_OK) begin
                        if (sticky && powered) begin
                            st_q <= S_CLR;
                        end else if (sticky) begin
                            status_q <= ST_POWER;
                            st_q     <= S_RSP;
                        end else begin
                            st_q <= S_RSP;
                        end
                    end else if (scan_ack == ACK_WAIT) begin
                        if (retry_q == retry_max) begin
                            st_q <= S_ABT;
                        end else begin
                            retry_q <= retry_q + 1'b1;
                            st_q    <= S_CSR;
                        end
                    end else begin
                        status_q <= ST_ACKERR;
                        st_q     <= S_RSP;
                    end
                end
                S_ABT:  if (scan_done) begin
                    status_q <= ST_TIMEOUT;
                    st_q     <= S_RSP;
                end
                S_CLR:  if (scan_done) begin
                    status_q <= ST_STICKY;
                    st_q     <= S_RSP;
                end
                S_RSP:  st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Name the scan each step wants from the formatter.
    always_comb begin
        case (st_q)
            S_SEL:   op = OP_SEL;
            S_ACC:   op = OP_ACC;
            S_RDB:   op = OP_RDB;
            S_CSR:   op = OP_CSR;
            S_CSB:   op = OP_RDB;
            S_ABT:   op = OP_ABT;
            S_CLR:   op = OP_CLR;
            default: op = OP_NONE;
        endcase
    end

    // Drive handshakes and the response from the held state.
    always_comb begin
        cmd_ready  = (st_q == S_IDLE);
        sel_done   = (st_q == S_SEL) && scan_done;
        rsp_valid  = (st_q == S_RSP);
        rsp_status = status_q;
        rsp_rdata  = rdata_q;
    end

endmodule

// File: rtl/dbg_txn_seq.sv
// Top level: debug port transaction sequencer. Joins the step machine,
// the bank copy, the idle-count choice and the scan formatter.
// Assumes one command in flight and a scan engine that pulses scan_done.
module dbg_txn_seq
    import dts_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int AP_W     = 8,
    parameter int IDLE_W   = 8,
    parameter int RETRY_W  = 8,
    parameter int IR_W     = 4,
    parameter int ORUN_BIT = 1,
    parameter int SERR_BIT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_is_ap,
    input  logic               cmd_rnw,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [DATA_W-1:0]  cmd_wdata,
    output logic               rsp_valid,
    output logic [2:0]         rsp_status,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic [AP_W-1:0]    cfg_ap_num,
    input  logic [IDLE_W-1:0]  cfg_idle_tck,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    input  logic [DATA_W-1:0]  cfg_ctrl_base,
    output logic               scan_req,
    output logic [IR_W-1:0]    scan_ir,
    output logic [DATA_W+2:0]  scan_dr,
    output logic [IDLE_W-1:0]  scan_idle,
    input  logic               scan_done,
    input  logic [2:0]         scan_ack,
    input  logic [DATA_W-1:0]  scan_rdata
);

    localparam int BANK_LSB = 4;
    localparam int BANK_W   = ADDR_W - BANK_LSB;

    logic              q_is_ap;
    logic              q_rnw;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    op_e               op;
    logic              sel_done;
    logic              need_sel;
    logic [IDLE_W-1:0] acc_idle;

    dts_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RETRY_W(RETRY_W),
        .ORUN_BIT(ORUN_BIT), .SERR_BIT(SERR_BIT), .PWR_W(4)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_is_ap(cmd_is_ap), .cmd_rnw(cmd_rnw),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .need_sel(need_sel), .retry_max(cfg_retry_max),
        .q_is_ap(q_is_ap), .q_rnw(q_rnw), .q_addr(q_addr), .q_wdata(q_wdata),
        .op(op), .sel_done(sel_done),
        .scan_done(scan_done), .scan_ack(scan_ack), .scan_rdata(scan_rdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
    );

    dts_bank_track #(.BANK_W(BANK_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .is_ap(q_is_ap), .bank(q_addr[ADDR_W-1:BANK_LSB]),
        .upd(sel_done), .need_sel(need_sel)
    );

    dts_idle_pick #(.ADDR_W(ADDR_W), .IDLE_W(IDLE_W)) u_idle (
        .is_ap(q_is_ap), .addr(q_addr), .cfg_idle(cfg_idle_tck), .idle(acc_idle)
    );

    dts_scan_fmt #(
        .DATA_W(DATA_W), .AP_W(AP_W), .BANK_W(BANK_W), .IDLE_W(IDLE_W),
        .IR_W(IR_W), .ORUN_BIT(ORUN_BIT), .SERR_BIT(SERR_BIT)
    ) u_fmt (
        .op(op), .is_ap(q_is_ap), .rnw(q_rnw), .reg_a(q_addr[3:2]),
        .bank(q_addr[ADDR_W-1:BANK_LSB]), .wdata(q_wdata),
        .ap_num(cfg_ap_num), .ctrl_base(cfg_ctrl_base), .acc_idle(acc_idle),
        .req(scan_req), .ir(scan_ir), .dr(scan_dr), .idle(scan_idle)
    );

endmodule

// File: rtl/dts_chk.sv
// Protocol checker for the sequencer, bound to the top module.
// Assumes the default data width of 32 bits.
module dts_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic        scan_req,
    input logic [3:0]  scan_ir,
    input logic [34:0] scan_dr,
    input logic [7:0]  scan_idle,
    input logic        scan_done
);

    // R12
    scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && !scan_done) |=> (scan_req && $stable(scan_ir) &&
                                      $stable(scan_dr) && $stable(scan_idle)));

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!scan_req && !rsp_valid));

    // R7
    abort_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && scan_ir == 4'h8) |-> (scan_dr == 35'd8));

    // R5
    idle_ap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && scan_idle != 8'd0) |-> (scan_ir == 4'hB));

    // R3
    ir_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |-> (scan_ir == 4'h8 || scan_ir == 4'hA || scan_ir == 4'hB));

    // R6
    rsp_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(scan_done));

endmodule

bind dbg_txn_seq dts_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .scan_req(scan_req), .scan_ir(scan_ir), .scan_dr(scan_dr),
    .scan_idle(scan_idle), .scan_done(scan_done)
);

// File: tb/test_dbg_txn_seq.sv
module test_dbg_txn_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_ready, cmd_is_ap, cmd_rnw;
    logic [7:0]  cmd_addr;
    logic [31:0] cmd_wdata;
    logic        rsp_valid;
    logic [2:0]  rsp_status;
    logic [31:0] rsp_rdata;
    logic [7:0]  cfg_ap_num, cfg_idle_tck, cfg_retry_max;
    logic [31:0] cfg_ctrl_base;
    logic        scan_req;
    logic [3:0]  scan_ir;
    logic [34:0] scan_dr;
    logic [7:0]  scan_idle;
    logic        scan_done;
    logic [2:0]  scan_ack;
    logic [31:0] scan_rdata;

    always #5 clk = ~clk;

    dbg_txn_seq i_dbg_txn_seq (.*);

    localparam logic [31:0] ID_WORD = 32'h0BB1_1477;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // target model and scan expectations
    logic [46:0] exp_q[$];
    string       tag_q[$];
    logic [2:0]  stat_ack_q[$];
    logic [31:0] ap_mem [256];
    logic [31:0] t_sel, t_ctrl, posted;
    bit          prev_csr;
    bit          m_valid;
    logic [3:0]  m_bank;
    logic [46:0] got, want;
    string       tag;
    logic [1:0]  ta;
    logic        tr;
    logic [31:0] td;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [3:0] ir, input logic [31:0] d,
                            input logic [1:0] a, input logic r,
                            input logic [7:0] idl, input string t);
        exp_q.push_back({ir, d, a, r, idl});
        tag_q.push_back(t);
    endtask

    // scan engine with a behavioural target behind it
    initial begin
        scan_done = 1'b0; scan_ack = 3'b000; scan_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n && scan_req) begin
                got = {scan_ir, scan_dr, scan_idle};
                chk(cmd_ready == 1'b0, "R11", "ready during scan", 64'(cmd_ready), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected scan", 64'(got), 0);
                end else begin
                    want = exp_q.pop_front();
                    tag  = tag_q.pop_front();
                    chk(got == want, tag, "scan word", 64'(got), 64'(want));
                end
                ta = scan_dr[2:1]; tr = scan_dr[0]; td = scan_dr[34:3];
                scan_rdata = posted;
                scan_ack   = 3'b010;
                if (scan_ir == 4'hA) begin
                    case (ta)
                        2'd0: if (tr) posted = ID_WORD;
                        2'd1: if (tr) posted = t_ctrl;
                              else t_ctrl = t_ctrl & ~(td & 32'h22);
                        2'd2: if (!tr) t_sel = td;
                        default: if (tr && prev_csr && stat_ack_q.size() > 0)
                                     scan_ack = stat_ack_q.pop_front();
                    endcase
                end else if (scan_ir == 4'hB) begin
                    if (tr) posted = ap_mem[{t_sel[7:4], ta, 2'b00}];
                    else ap_mem[{t_sel[7:4], ta, 2'b00}] = td;
                end
                prev_csr = (scan_ir == 4'hA) && (ta == 2'd1) && tr;
                repeat (2) @(negedge clk);
                scan_done = 1'b1;
                @(negedge clk);
                scan_done = 1'b0;
            end
        end
    end

    // one command: build expected scans from the requirements, run, compare
    task automatic do_cmd(input bit ap, input bit rnw, input logic [7:0] addr,
                          input logic [31:0] wd, input logic [2:0] exp_st,
                          input logic [31:0] exp_rd, input string req);
        logic [2:0] acks[$];
        int retries = 0;
        int ai = 0;
        bit fin = 1'b0;
        int wait_cyc = 0;
        logic [2:0] a;
        logic [7:0] idl;
        acks = stat_ack_q;
        if (ap && (!m_valid || addr[7:4] != m_bank)) begin
            push_exp(4'hA, {cfg_ap_num, 16'h0, addr[7:4], 4'h0}, 2'b10, 1'b0, 8'd0, "R2");
            m_valid = 1'b1; m_bank = addr[7:4];
        end
        idl = (ap && (addr == 8'h0C || addr[7:4] == 4'h1)) ? cfg_idle_tck : 8'd0;
        push_exp(ap ? 4'hB : 4'hA, rnw ? 32'h0 : wd, addr[3:2], rnw, idl,
                 (idl != 0) ? "R5" : "R3");
        if (rnw) push_exp(4'hA, 32'h0, 2'b11, 1'b1, 8'd0, "R4");
        while (!fin) begin
            push_exp(4'hA, 32'h0, 2'b01, 1'b1, 8'd0, "R6");
            push_exp(4'hA, 32'h0, 2'b11, 1'b1, 8'd0, "R6");
            a = (ai < acks.size()) ? acks[ai] : 3'b010;
            ai++;
            if (a == 3'b001) begin
                if (retries == int'(cfg_retry_max)) begin
                    push_exp(4'h8, 32'h1, 2'b00, 1'b0, 8'd0, "R7");
                    fin = 1'b1;
                end else retries++;
            end else fin = 1'b1;
        end
        if (a == 3'b010 && (t_ctrl[1] || t_ctrl[5]) && (&t_ctrl[31:28]))
            push_exp(4'hA, cfg_ctrl_base | 32'h22, 2'b01, 1'b0, 8'd0, "R9");

        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_ap = ap; cmd_rnw = rnw; cmd_addr = addr; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!rsp_valid && wait_cyc < 2000) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk(rsp_valid == 1'b1, req, "response seen", 64'(rsp_valid), 1);
        chk(rsp_status == exp_st, req, "status", 64'(rsp_status), 64'(exp_st));
        if (rnw && exp_st == 3'd0)
            chk(rsp_rdata == exp_rd, "R4", "read data", 64'(rsp_rdata), 64'(exp_rd));
        chk(exp_q.size() == 0, req, "scans left", 64'(exp_q.size()), 0);
        exp_q.delete(); tag_q.delete(); stat_ack_q.delete();
        @(negedge clk);
        chk(rsp_valid == 1'b0 && cmd_ready == 1'b1, "R11", "pulse then idle",
            64'({rsp_valid, cmd_ready}), 64'(2'b01));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ap_mem[i] = 32'h0;
        ap_mem[8'h14] = 32'hCAFE_0014;
        t_sel = '0; t_ctrl = 32'hF000_0000; posted = '0; prev_csr = 1'b0;
        m_valid = 1'b0; m_bank = '0;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_is_ap = 1'b0; cmd_rnw = 1'b0;
        cmd_addr = '0; cmd_wdata = '0;
        cfg_ap_num = 8'h02; cfg_idle_tck = 8'd5; cfg_retry_max = 8'd3;
        cfg_ctrl_base = 32'h5000_0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1 && scan_req == 1'b0 && rsp_valid == 1'b0, "R1",
            "reset state", 64'({cmd_ready, scan_req, rsp_valid}), 64'(3'b100));

        do_cmd(1, 0, 8'h04, 32'hA5A5_0001, 3'd0, 0, "R1");              // first AP: select
        do_cmd(1, 1, 8'h04, 0, 3'd0, 32'hA5A5_0001, "R2");              // same bank, no select
        do_cmd(1, 0, 8'h0C, 32'h1234_5678, 3'd0, 0, "R5");              // data reg idle
        do_cmd(1, 1, 8'h14, 0, 3'd0, 32'hCAFE_0014, "R2");              // bank 1, idle
        do_cmd(1, 0, 8'h24, 32'h0000_0024, 3'd0, 0, "R3");              // bank 2, no idle
        cfg_idle_tck = 8'd0;
        do_cmd(1, 0, 8'h0C, 32'h8765_4321, 3'd0, 0, "R5");              // zero idle count
        cfg_idle_tck = 8'd5;
        do_cmd(1, 1, 8'h0C, 0, 3'd0, 32'h8765_4321, "R4");
        do_cmd(0, 1, 8'h00, 0, 3'd0, ID_WORD, "R3");                    // DP read
        stat_ack_q = '{3'b001, 3'b001};
        do_cmd(1, 1, 8'h04, 0, 3'd0, 32'hA5A5_0001, "R6");              // WAIT retried
        stat_ack_q = '{3'b001, 3'b001, 3'b001, 3'b001};
        do_cmd(1, 0, 8'h1C, 32'h0000_001C, 3'd1, 0, "R7");              // timeout
        cfg_retry_max = 8'd0;
        stat_ack_q = '{3'b001};
        do_cmd(0, 1, 8'h00, 0, 3'd1, 0, "R7");                          // zero budget
        cfg_retry_max = 8'd3;
        stat_ack_q = '{3'b100};
        do_cmd(0, 1, 8'h00, 0, 3'd2, 0, "R8");                          // bad ack
        t_ctrl = 32'hF000_0002;
        do_cmd(1, 0, 8'h08, 32'h0000_0008, 3'd3, 0, "R9");              // sticky clear
        chk(t_ctrl == 32'hF000_0000, "R9", "sticky cleared at target",
            64'(t_ctrl), 64'(32'hF000_0000));
        do_cmd(0, 1, 8'h00, 0, 3'd0, ID_WORD, "R9");                    // clean after clear
        t_ctrl = 32'h7000_0020;
        do_cmd(0, 1, 8'h00, 0, 3'd4, 0, "R10");                         // power lost
        chk(t_ctrl == 32'h7000_0020, "R10", "no clear write",
            64'(t_ctrl), 64'(32'h7000_0020));
        t_ctrl = 32'hF000_0000;
        do_cmd(1, 1, 8'h14, 0, 3'd0, 32'hCAFE_0014, "R10");             // clean again

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule